// File: doc/BRIEF.md
# Accumulator Bit Manipulation Unit

This unit carries out the shift and bit-field work on a 36-bit accumulator. A 4-bit function code and a 4-bit auxiliary code together choose the operation. They also choose where the shift amount or the field descriptor comes from: one of four 16-bit auxiliary registers, a second accumulator, or a 16-bit immediate. The operations are:

- logical and arithmetic shifts in either direction;
- exponent detection and normalization;
- sign-filled and zero-filled field extraction;
- field insertion;
- exchange with one of two alternate accumulators.

The host datapath gives the operands and codes together with `valid_i`. One clock later the unit returns the registered result and its flags. In the same cycle it returns write strobes for any side-effect. Normalization writes its shift count to an auxiliary register. An exchange writes the source accumulator into the alternate.

Top module: `acc_bmu`

## Requirements
- R1: Result, flags and strobes are registered and appear on the clock edge after a cycle with `valid_i` high, with `res_vld_o` high. In a cycle after `valid_i` low, `res_vld_o`, `ar_wr_o`, `alt_wr_o` and `illegal_o` are low and `res_o` keeps its value.
- R2: Function 0000 / 0001 with auxiliary code 00xx shifts the source logically right / left by auxiliary register xx.
- R3: The shift amount is the low 6 bits of its source, read as two's complement. A negative amount shifts the opposite way by its magnitude (up to 32) and keeps the logical or arithmetic kind.
- R4: Auxiliary code 10xx with function 0000 / 0001 selects arithmetic right / left shifts. Arithmetic right fills with bit 35, and logical right fills with zeros. Both left kinds fill with zeros.
- R5: Functions 1000 / 1001 take the amount from `amt_acc_i`, and 1100 / 1101 take it from `imm_i`. Bit 0 of the function selects left. Auxiliary code 0000 selects logical and 1000 selects arithmetic.
- R6: Function 0000 with auxiliary code 1100 returns the exponent, sign-extended. The exponent is the count of leading bits below bit 35 equal to bit 35, minus 4. Its range is -4 to 31.
- R7: Function 0001 with auxiliary code 11xx shifts the source arithmetically left by the exponent (right if it is negative). It also pulses `ar_wr_o` with `ar_sel_o`=xx and `ar_wdata_o` holding the exponent sign-extended to 16 bits.
- R8: A descriptor carries the field width in bits 15:8 and the offset in bits 7:0. It comes from `imm_i` for function 1110, or from auxiliary register xx for function 0010. Signed extraction uses 1110/0000 or 0010/00xx and returns source bits [offset+width-1:offset] sign-extended. Zero-filled extraction uses 1110/0100 or 0010/01xx.
- R9: For extraction, width 0 gives 0 and a width of 36 or more keeps all shifted bits. Source bits above 35 read as zero.
- R10: Insertion uses 1110/1000 with an immediate descriptor or 1010/10xx with auxiliary register xx. It returns `dst_acc_i` with bits [offset+width-1:offset] replaced by the low bits of the source. Positions above 35 are dropped.
- R11: Function 0111 with auxiliary code 000y returns alternate accumulator y. It pulses `alt_wr_o` with `alt_sel_o`=y and `alt_wdata_o` equal to the source.
- R12: Any other code pair gives result 0 with `illegal_o` high and no write strobe.
- R13: `zero_o` is high when the registered result is 0. `neg_o` equals bit 35 of the registered result.
- R14: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| func_i | input | 4 | Function code |
| aux_i | input | 4 | Auxiliary code |
| src_acc_i | input | 36 | Source accumulator |
| amt_acc_i | input | 6 | Low bits of the accumulator holding a shift amount |
| dst_acc_i | input | 36 | Current destination value, used by insertion |
| alt0_i | input | 36 | Alternate accumulator 0 |
| alt1_i | input | 36 | Alternate accumulator 1 |
| ar_i | input | 64 | Four auxiliary registers, register n in bits 16n+15:16n |
| imm_i | input | 16 | Immediate |
| res_o | output | 36 | Registered result |
| res_vld_o | output | 1 | Result valid |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result bit 35 |
| illegal_o | output | 1 | Undefined code pair |
| ar_wr_o | output | 1 | Auxiliary register write strobe |
| ar_sel_o | output | 2 | Auxiliary register to write |
| ar_wdata_o | output | 16 | Auxiliary register write data |
| alt_wr_o | output | 1 | Alternate accumulator write strobe |
| alt_sel_o | output | 1 | Alternate accumulator to write |
| alt_wdata_o | output | 36 | Alternate accumulator write data |

## Verification
The only internal state is the output register, so any error in decode, shifting, masking or sign-run counting shows on `res_o` or a strobe on the edge right after the operation. A mis-decoded code pair shows up in one of these ways:

- the wrong fill at the top of the result;
- a field off by its offset;
- a write strobe raised for an operation that has no side-effect.

A stale or sticky output register shows in the idle cycle after an operation. In that cycle `res_vld_o` and the strobes must drop while the result holds.

// File: rtl/acc_bmu_pkg.sv
package acc_bmu_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_SHIFT,
        OP_EXP,
        OP_NORM,
        OP_EXTS,
        OP_EXTZ,
        OP_INS,
        OP_XCHG
    } bmu_op_e;

    typedef enum logic [1:0] {
        SRC_AR,
        SRC_ACC,
        SRC_IMM
    } bmu_src_e;

    typedef struct packed {
        bmu_op_e    op;
        logic       left;
        logic       arith;
        bmu_src_e   src;
        logic [1:0] ar_idx;
        logic       alt_idx;
    } bmu_dec_t;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
    import acc_bmu_pkg::*;
(
    input  logic [3:0] func_i,
    input  logic [3:0] aux_i,
    output bmu_dec_t   dec_o
);

    always_comb begin
        dec_o         = '0;
        dec_o.op      = OP_NONE;
        dec_o.src     = SRC_AR;
        dec_o.ar_idx  = aux_i[1:0];
        dec_o.alt_idx = aux_i[0];
        case (func_i)
            4'b0000: begin
                if (aux_i[3:2] == 2'b00) begin
                    dec_o.op = OP_SHIFT;
                end else if (aux_i[3:2] == 2'b10) begin
                    dec_o.op    = OP_SHIFT;
                    dec_o.arith = 1'b1;
                end else if (aux_i == 4'b1100) begin
                    dec_o.op = OP_EXP;
                end
            end
            4'b0001: begin
                dec_o.left = 1'b1;
                if (aux_i[3:2] == 2'b00) begin
                    dec_o.op = OP_SHIFT;
                end else if (aux_i[3:2] == 2'b10) begin
                    dec_o.op    = OP_SHIFT;
                    dec_o.arith = 1'b1;
                end else if (aux_i[3:2] == 2'b11) begin
                    dec_o.op = OP_NORM;
                end
            end
            4'b1000, 4'b1001, 4'b1100, 4'b1101: begin
                dec_o.left = func_i[0];
                dec_o.src  = func_i[2] ? SRC_IMM : SRC_ACC;
                if (aux_i == 4'b0000) begin
                    dec_o.op = OP_SHIFT;
                end else if (aux_i == 4'b1000) begin
                    dec_o.op    = OP_SHIFT;
                    dec_o.arith = 1'b1;
                end
            end
            4'b1110: begin
                dec_o.src = SRC_IMM;
                case (aux_i)
                    4'b0000: dec_o.op = OP_EXTS;
                    4'b0100: dec_o.op = OP_EXTZ;
                    4'b1000: dec_o.op = OP_INS;
                    default: dec_o.op = OP_NONE;
                endcase
            end
            4'b0010: begin
                if (aux_i[3:2] == 2'b00) begin
                    dec_o.op = OP_EXTS;
                end else if (aux_i[3:2] == 2'b01) begin
                    dec_o.op = OP_EXTZ;
                end
            end
            4'b1010: begin
                if (aux_i[3:2] == 2'b10) begin
                    dec_o.op = OP_INS;
                end
            end
            4'b0111: begin
                if (aux_i[3:1] == 3'b000) begin
                    dec_o.op = OP_XCHG;
                end
            end
            default: dec_o.op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/bmu_shift.sv
module bmu_shift #(
    parameter int W     = 36,
    parameter int AMT_W = 6
) (
    input  logic [W-1:0]     data_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             left_i,
    input  logic             arith_i,
    output logic [W-1:0]     data_o
);

    logic             amt_neg;
    logic [AMT_W-1:0] amt_mag;
    logic             go_left;

    always_comb begin
        amt_neg = amt_i[AMT_W-1];
        amt_mag = amt_neg ? (~amt_i + AMT_W'(1)) : amt_i;
        go_left = left_i ^ amt_neg;
        if (go_left) begin
            data_o = data_i << amt_mag;
        end else if (arith_i) begin
            data_o = $signed(data_i) >>> amt_mag;
        end else begin
            data_o = data_i >> amt_mag;
        end
    end

endmodule

// File: rtl/bmu_lsc.sv
module bmu_lsc #(
    parameter int W       = 36,
    parameter int GUARD_W = 4,
    parameter int AMT_W   = 6
) (
    input  logic [W-1:0]     data_i,
    output logic [AMT_W-1:0] exp_o
);

    localparam int CNT_W = $clog2(W);

    logic [CNT_W-1:0] run_cnt;
    logic             in_run;

    always_comb begin
        run_cnt = '0;
        in_run  = 1'b1;
        for (int i = W - 2; i >= 0; i--) begin
            if (in_run && (data_i[i] == data_i[W-1])) begin
                run_cnt = run_cnt + CNT_W'(1);
            end else begin
                in_run = 1'b0;
            end
        end
        exp_o = AMT_W'(run_cnt) - AMT_W'(GUARD_W);
    end

endmodule

// File: rtl/bmu_field.sv
module bmu_field #(
    parameter int W  = 36,
    parameter int FW = 8
) (
    input  logic [W-1:0]    src_i,
    input  logic [W-1:0]    dst_i,
    input  logic [2*FW-1:0] desc_i,
    input  logic            sign_i,
    output logic [W-1:0]    ext_o,
    output logic [W-1:0]    ins_o
);

    localparam logic [FW-1:0] W_F = FW'(W);

    logic [FW-1:0] fld_w;
    logic [FW-1:0] fld_off;
    logic [W-1:0]  fmask;
    logic [W-1:0]  imask;
    logic [W-1:0]  down;
    logic [W-1:0]  top_bit;
    logic          fill;

    always_comb begin
        fld_w   = desc_i[2*FW-1:FW];
        fld_off = desc_i[FW-1:0];
        fmask   = (fld_w >= W_F) ? '1 : ~({W{1'b1}} << fld_w);
        down    = src_i >> fld_off;
        top_bit = down >> (fld_w - FW'(1));
        fill    = sign_i && (fld_w != '0) && top_bit[0];
        ext_o   = (down & fmask) | (fill ? ~fmask : '0);
        imask   = fmask << fld_off;
        ins_o   = (dst_i & ~imask) | ((src_i << fld_off) & imask);
    end

endmodule

// File: rtl/acc_bmu.sv
module acc_bmu
    import acc_bmu_pkg::*;
#(
    parameter int ACC_W   = 36,
    parameter int AUX_W   = 16,
    parameter int NUM_AR  = 4,
    parameter int AMT_W   = 6,
    parameter int GUARD_W = 4,
    parameter int IMM_W   = 16,
    parameter int FW      = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          valid_i,
    input  logic [3:0]                    func_i,
    input  logic [3:0]                    aux_i,
    input  logic [ACC_W-1:0]              src_acc_i,
    input  logic [AMT_W-1:0]              amt_acc_i,
    input  logic [ACC_W-1:0]              dst_acc_i,
    input  logic [ACC_W-1:0]              alt0_i,
    input  logic [ACC_W-1:0]              alt1_i,
    input  logic [NUM_AR-1:0][AUX_W-1:0]  ar_i,
    input  logic [IMM_W-1:0]              imm_i,
    output logic [ACC_W-1:0]              res_o,
    output logic                          res_vld_o,
    output logic                          zero_o,
    output logic                          neg_o,
    output logic                          illegal_o,
    output logic                          ar_wr_o,
    output logic [$clog2(NUM_AR)-1:0]     ar_sel_o,
    output logic [AUX_W-1:0]              ar_wdata_o,
    output logic                          alt_wr_o,
    output logic                          alt_sel_o,
    output logic [ACC_W-1:0]              alt_wdata_o
);

    localparam int AR_SEL_W = $clog2(NUM_AR);
    localparam int DESC_W   = 2 * FW;

    typedef struct packed {
        logic [ACC_W-1:0]    res;
        logic                vld;
        logic                zero;
        logic                neg;
        logic                ill;
        logic                ar_wr;
        logic [AR_SEL_W-1:0] ar_sel;
        logic [AUX_W-1:0]    ar_wdata;
        logic                alt_wr;
        logic                alt_sel;
        logic [ACC_W-1:0]    alt_wdata;
    } bmu_state_t;

    bmu_state_t st_d, st_q;
    bmu_dec_t   dec;

    logic [AUX_W-1:0]  ar_pick;
    logic [AMT_W-1:0]  amt_sel;
    logic [AMT_W-1:0]  sh_amt;
    logic              sh_left;
    logic              sh_arith;
    logic [ACC_W-1:0]  sh_out;
    logic [AMT_W-1:0]  exp_val;
    logic [DESC_W-1:0] desc;
    logic [ACC_W-1:0]  ext_val;
    logic [ACC_W-1:0]  ins_val;
    logic              is_norm;

    bmu_decode u_dec (
        .func_i (func_i),
        .aux_i  (aux_i),
        .dec_o  (dec)
    );

    always_comb begin
        ar_pick = ar_i[AR_SEL_W'(dec.ar_idx)];
        case (dec.src)
            SRC_ACC: amt_sel = amt_acc_i;
            SRC_IMM: amt_sel = imm_i[AMT_W-1:0];
            default: amt_sel = ar_pick[AMT_W-1:0];
        endcase
        desc     = (dec.src == SRC_IMM) ? imm_i[DESC_W-1:0] : ar_pick[DESC_W-1:0];
        is_norm  = (dec.op == OP_NORM);
        sh_amt   = is_norm ? exp_val : amt_sel;
        sh_left  = is_norm ? 1'b1 : dec.left;
        sh_arith = is_norm ? 1'b1 : dec.arith;
    end

    bmu_lsc #(
        .W       (ACC_W),
        .GUARD_W (GUARD_W),
        .AMT_W   (AMT_W)
    ) u_lsc (
        .data_i (src_acc_i),
        .exp_o  (exp_val)
    );

    bmu_shift #(
        .W     (ACC_W),
        .AMT_W (AMT_W)
    ) u_shift (
        .data_i  (src_acc_i),
        .amt_i   (sh_amt),
        .left_i  (sh_left),
        .arith_i (sh_arith),
        .data_o  (sh_out)
    );

    bmu_field #(
        .W  (ACC_W),
        .FW (FW)
    ) u_field (
        .src_i  (src_acc_i),
        .dst_i  (dst_acc_i),
        .desc_i (desc),
        .sign_i (dec.op == OP_EXTS),
        .ext_o  (ext_val),
        .ins_o  (ins_val)
    );

    always_comb begin
        logic [ACC_W-1:0] r;
        st_d        = st_q;
        st_d.vld    = 1'b0;
        st_d.ill    = 1'b0;
        st_d.ar_wr  = 1'b0;
        st_d.alt_wr = 1'b0;
        r           = '0;
        if (valid_i) begin
            case (dec.op)
                OP_SHIFT: r = sh_out;
                OP_NORM: begin
                    r             = sh_out;
                    st_d.ar_wr    = 1'b1;
                    st_d.ar_sel   = AR_SEL_W'(dec.ar_idx);
                    st_d.ar_wdata = {{(AUX_W-AMT_W){exp_val[AMT_W-1]}}, exp_val};
                end
                OP_EXP:  r = {{(ACC_W-AMT_W){exp_val[AMT_W-1]}}, exp_val};
                OP_EXTS, OP_EXTZ: r = ext_val;
                OP_INS:  r = ins_val;
                OP_XCHG: begin
                    r              = dec.alt_idx ? alt1_i : alt0_i;
                    st_d.alt_wr    = 1'b1;
                    st_d.alt_sel   = dec.alt_idx;
                    st_d.alt_wdata = src_acc_i;
                end
                default: st_d.ill = 1'b1;
            endcase
            st_d.vld  = 1'b1;
            st_d.res  = r;
            st_d.zero = (r == '0);
            st_d.neg  = r[ACC_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_o       = st_q.res;
    assign res_vld_o   = st_q.vld;
    assign zero_o      = st_q.zero;
    assign neg_o       = st_q.neg;
    assign illegal_o   = st_q.ill;
    assign ar_wr_o     = st_q.ar_wr;
    assign ar_sel_o    = st_q.ar_sel;
    assign ar_wdata_o  = st_q.ar_wdata;
    assign alt_wr_o    = st_q.alt_wr;
    assign alt_sel_o   = st_q.alt_sel;
    assign alt_wdata_o = st_q.alt_wdata;

    // R1: an accepted operation produces a valid result on the next edge
    p_vld_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> res_vld_o);

    // R1: idle cycles drop valid and keep the result
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!res_vld_o && $stable(res_o) && !ar_wr_o && !alt_wr_o));

    // R7, R11, R12: at most one side-effect or error per result
    p_one_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ar_wr_o, alt_wr_o, illegal_o}));

    // R12: undefined codes give a zero, valid result
    p_illegal_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (res_vld_o && res_o == '0));

    // R6: normalization count stays inside the exponent range
    p_exp_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ar_wr_o |-> ($signed(ar_wdata_o) >= -GUARD_W && $signed(ar_wdata_o) <= ACC_W - 1 - GUARD_W));

    // R11: exchange strobe only with a valid result
    p_xchg_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        alt_wr_o |-> res_vld_o);

endmodule

// File: tb/acc_bmu_tb_top.sv
`timescale 1ns/1ps
module acc_bmu_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              valid_i = 1'b0;
    logic [3:0]        func_i = '0;
    logic [3:0]        aux_i = '0;
    logic [35:0]       src_acc_i = '0;
    logic [5:0]        amt_acc_i = '0;
    logic [35:0]       dst_acc_i = '0;
    logic [35:0]       alt0_i = 36'h5_5555_AAAA;
    logic [35:0]       alt1_i = 36'hA_AAAA_5555;
    logic [3:0][15:0]  ar_i = {16'h0410, 16'h0804, 16'h003D, 16'h0004};
    logic [15:0]       imm_i = '0;
    logic [35:0]       res_o;
    logic              res_vld_o, zero_o, neg_o, illegal_o;
    logic              ar_wr_o, alt_wr_o, alt_sel_o;
    logic [1:0]        ar_sel_o;
    logic [15:0]       ar_wdata_o;
    logic [35:0]       alt_wdata_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    acc_bmu dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .func_i(func_i), .aux_i(aux_i),
        .src_acc_i(src_acc_i), .amt_acc_i(amt_acc_i), .dst_acc_i(dst_acc_i),
        .alt0_i(alt0_i), .alt1_i(alt1_i), .ar_i(ar_i), .imm_i(imm_i),
        .res_o(res_o), .res_vld_o(res_vld_o), .zero_o(zero_o), .neg_o(neg_o),
        .illegal_o(illegal_o), .ar_wr_o(ar_wr_o), .ar_sel_o(ar_sel_o),
        .ar_wdata_o(ar_wdata_o), .alt_wr_o(alt_wr_o), .alt_sel_o(alt_sel_o),
        .alt_wdata_o(alt_wdata_o)
    );

    typedef struct packed {
        logic [3:0]  f;
        logic [3:0]  a;
        logic [35:0] src;
        logic [5:0]  amt;
        logic [35:0] dst;
        logic [15:0] imm;
        logic [35:0] exp;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 41;
    // aux registers: ar0=4, ar1=-3, ar2=0x0804 (w8 o4), ar3=0x0410 (w4 o16)
    localparam vec_t VECS [NV] = '{
        '{4'h0, 4'h0, 36'h0_1234_5678, 6'd0,  36'h0, 16'h0000, 36'h0_0123_4567, 1'b0, 4'd2},  // R2
        '{4'h0, 4'h1, 36'h0_1234_5678, 6'd0,  36'h0, 16'h0000, 36'h0_91A2_B3C0, 1'b0, 4'd3},  // R3
        '{4'h0, 4'h8, 36'h8_0000_0010, 6'd0,  36'h0, 16'h0000, 36'hF_8000_0001, 1'b0, 4'd4},  // R4
        '{4'h0, 4'h0, 36'h8_0000_0010, 6'd0,  36'h0, 16'h0000, 36'h0_8000_0001, 1'b0, 4'd4},  // R4
        '{4'h1, 4'h0, 36'hF_0000_0001, 6'd0,  36'h0, 16'h0000, 36'h0_0000_0010, 1'b0, 4'd2},  // R2
        '{4'h1, 4'h8, 36'hF_0000_0001, 6'd0,  36'h0, 16'h0000, 36'h0_0000_0010, 1'b0, 4'd4},  // R4
        '{4'h1, 4'h9, 36'h8_0000_0008, 6'd0,  36'h0, 16'h0000, 36'hF_0000_0001, 1'b0, 4'd3},  // R3
        '{4'h8, 4'h0, 36'h0_0000_FF00, 6'd8,  36'h0, 16'h0000, 36'h0_0000_00FF, 1'b0, 4'd5},  // R5
        '{4'h8, 4'h8, 36'h8_0000_0000, 6'h1F, 36'h0, 16'h0000, 36'hF_FFFF_FFF0, 1'b0, 4'd5},  // R5
        '{4'h9, 4'h0, 36'h8_0000_0004, 6'h3E, 36'h0, 16'h0000, 36'h2_0000_0001, 1'b0, 4'd3},  // R3
        '{4'h9, 4'h8, 36'h8_0000_0004, 6'h3E, 36'h0, 16'h0000, 36'hE_0000_0001, 1'b0, 4'd3},  // R3
        '{4'hC, 4'h0, 36'h0_1234_5678, 6'd0,  36'h0, 16'h0010, 36'h0_0000_1234, 1'b0, 4'd5},  // R5
        '{4'hD, 4'h8, 36'h0_0000_00AB, 6'd0,  36'h0, 16'h0008, 36'h0_0000_AB00, 1'b0, 4'd5},  // R5
        '{4'hC, 4'h8, 36'hF_FFFF_FFFE, 6'd0,  36'h0, 16'h0001, 36'hF_FFFF_FFFF, 1'b0, 4'd5},  // R5
        '{4'hD, 4'h0, 36'hF_0000_0000, 6'd0,  36'h0, 16'h0020, 36'h0_0000_000F, 1'b0, 4'd3},  // R3
        '{4'h0, 4'hC, 36'h0_0000_0001, 6'd0,  36'h0, 16'h0000, 36'h0_0000_001E, 1'b0, 4'd6},  // R6
        '{4'h0, 4'hC, 36'h8_0000_0000, 6'd0,  36'h0, 16'h0000, 36'hF_FFFF_FFFC, 1'b0, 4'd6},  // R6
        '{4'h0, 4'hC, 36'h0_0000_0000, 6'd0,  36'h0, 16'h0000, 36'h0_0000_001F, 1'b0, 4'd6},  // R6
        '{4'h0, 4'hC, 36'h0_8000_0000, 6'd0,  36'h0, 16'h0000, 36'hF_FFFF_FFFF, 1'b0, 4'd6},  // R6
        '{4'h0, 4'hC, 36'hF_FFFF_FFFF, 6'd0,  36'h0, 16'h0000, 36'h0_0000_001F, 1'b0, 4'd6},  // R6
        '{4'h1, 4'hC, 36'h0_0000_0001, 6'd0,  36'h0, 16'h0000, 36'h0_4000_0000, 1'b0, 4'd7},  // R7
        '{4'h1, 4'hD, 36'h8_0000_0000, 6'd0,  36'h0, 16'h0000, 36'hF_8000_0000, 1'b0, 4'd7},  // R7
        '{4'hE, 4'h0, 36'h0_0000_0F80, 6'd0,  36'h0, 16'h0804, 36'hF_FFFF_FFF8, 1'b0, 4'd8},  // R8
        '{4'hE, 4'h4, 36'h0_0000_0F80, 6'd0,  36'h0, 16'h0804, 36'h0_0000_00F8, 1'b0, 4'd8},  // R8
        '{4'h2, 4'h2, 36'h0_0000_0F80, 6'd0,  36'h0, 16'h0000, 36'hF_FFFF_FFF8, 1'b0, 4'd8},  // R8
        '{4'h2, 4'h7, 36'h0_000A_0000, 6'd0,  36'h0, 16'h0000, 36'h0_0000_000A, 1'b0, 4'd8},  // R8
        '{4'h2, 4'h3, 36'h0_000A_0000, 6'd0,  36'h0, 16'h0000, 36'hF_FFFF_FFFA, 1'b0, 4'd8},  // R8
        '{4'hE, 4'h0, 36'hF_FFFF_FFFF, 6'd0,  36'h0, 16'h0000, 36'h0_0000_0000, 1'b0, 4'd9},  // R9
        '{4'hE, 4'h4, 36'h9_8765_4321, 6'd0,  36'h0, 16'h3000, 36'h9_8765_4321, 1'b0, 4'd9},  // R9
        '{4'hE, 4'h0, 36'hA_0000_0000, 6'd0,  36'h0, 16'h0820, 36'h0_0000_000A, 1'b0, 4'd9},  // R9
        '{4'hE, 4'h4, 36'hF_FFFF_FFFF, 6'd0,  36'h0, 16'h0828, 36'h0_0000_0000, 1'b0, 4'd9},  // R9
        '{4'hE, 4'h8, 36'h0_0000_0012, 6'd0,  36'hF_FFFF_FFFF, 16'h0804, 36'hF_FFFF_F12F, 1'b0, 4'd10}, // R10
        '{4'hA, 4'hA, 36'h0_0000_0034, 6'd0,  36'hF_FFFF_FFFF, 16'h0000, 36'hF_FFFF_F34F, 1'b0, 4'd10}, // R10
        '{4'hE, 4'h8, 36'h0_0000_00FF, 6'd0,  36'h0, 16'h0820, 36'hF_0000_0000, 1'b0, 4'd10}, // R10
        '{4'hE, 4'h8, 36'h0_0000_00FF, 6'd0,  36'h1_2345_6789, 16'h0028, 36'h1_2345_6789, 1'b0, 4'd10}, // R10
        '{4'h7, 4'h0, 36'h0_0000_0077, 6'd0,  36'h0, 16'h0000, 36'h5_5555_AAAA, 1'b0, 4'd11}, // R11
        '{4'h7, 4'h1, 36'h0_0000_0077, 6'd0,  36'h0, 16'h0000, 36'hA_AAAA_5555, 1'b0, 4'd11}, // R11
        '{4'h0, 4'h4, 36'h0_1234_5678, 6'd0,  36'h0, 16'h0000, 36'h0_0000_0000, 1'b1, 4'd12}, // R12
        '{4'hF, 4'h0, 36'h0_1234_5678, 6'd0,  36'h0, 16'h0000, 36'h0_0000_0000, 1'b1, 4'd12}, // R12
        '{4'h8, 4'h1, 36'h0_1234_5678, 6'd0,  36'h0, 16'h0000, 36'h0_0000_0000, 1'b1, 4'd12}, // R12
        '{4'hA, 4'h2, 36'h0_1234_5678, 6'd0,  36'h0, 16'h0000, 36'h0_0000_0000, 1'b1, 4'd12}  // R12
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] f, input logic [3:0] a, input logic [35:0] src,
                         input logic [5:0] amt, input logic [35:0] dst, input logic [15:0] imm);
        @(negedge clk);
        func_i = f; aux_i = a; src_acc_i = src; amt_acc_i = amt; dst_acc_i = dst; imm_i = imm;
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R14: outputs during reset
        check("R14 res", 64'(res_o), 64'h0);
        check("R14 flags", 64'({res_vld_o, zero_o, neg_o, illegal_o, ar_wr_o, alt_wr_o}), 64'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].f, VECS[i].a, VECS[i].src, VECS[i].amt, VECS[i].dst, VECS[i].imm);
            check($sformatf("R%0d vec%0d res/illegal/vld", VECS[i].req, i),
                  64'({res_o, illegal_o, res_vld_o}), 64'({VECS[i].exp, VECS[i].ill, 1'b1}));
            // R13: flags follow the registered result
            check($sformatf("R13 vec%0d flags", i), 64'({zero_o, neg_o}),
                  64'({VECS[i].exp == 36'h0, VECS[i].exp[35]}));
        end

        // R7: normalize writes the count into the selected register
        apply(4'h1, 4'hE, 36'h0_0000_0001, 6'd0, 36'h0, 16'h0);
        check("R7 norm strobe/sel/data", 64'({ar_wr_o, ar_sel_o, ar_wdata_o, alt_wr_o}),
              64'({1'b1, 2'd2, 16'd30, 1'b0}));
        apply(4'h1, 4'hD, 36'h8_0000_0000, 6'd0, 36'h0, 16'h0);
        check("R7 norm negative count", 64'({ar_wr_o, ar_sel_o, ar_wdata_o}),
              64'({1'b1, 2'd1, 16'hFFFC}));

        // R1: idle cycle drops valid and strobes, keeps result
        @(negedge clk);
        check("R1 idle vld/strobes", 64'({res_vld_o, ar_wr_o, alt_wr_o, illegal_o}), 64'h0);
        check("R1 idle result hold", 64'(res_o), 64'h0_F_8000_0000);

        // R11: exchange strobes
        apply(4'h7, 4'h1, 36'h3_1415_9265, 6'd0, 36'h0, 16'h0);
        check("R11 xchg strobe/sel", 64'({alt_wr_o, alt_sel_o, ar_wr_o}), 64'({1'b1, 1'b1, 1'b0}));
        check("R11 xchg wdata", 64'(alt_wdata_o), 64'h0_3_1415_9265);

        // R2: plain shift raises no strobe
        apply(4'h0, 4'h0, 36'h0_0000_00F0, 6'd0, 36'h0, 16'h0);
        check("R2 shift no strobe", 64'({res_o, ar_wr_o, alt_wr_o}), 64'({36'h0_0000_000F, 2'b00}));

        // R12: illegal raises no strobe
        apply(4'h3, 4'h0, 36'h0_1234_5678, 6'd0, 36'h0, 16'h0);
        check("R12 illegal no strobe", 64'({illegal_o, ar_wr_o, alt_wr_o, res_vld_o}), 64'b1001);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule